// File: doc/BRIEF.md
# Tri-Port Interleaved Bus Exchanger

This block moves data between one processor-side address/data port (X) and two memory data ports: Y on the even path and Z on the odd path. Each memory port has two holding stages. A write stage is loaded from X and drives that memory port. A read stage is loaded from the memory port and can drive X. A path select picks which read stage reaches X.

Every stage is transparent. While its load input is high, the output follows the stage input. The value present at the last rising clock edge with load high is then held until load rises again.

Pins are modelled as separate input, output and byte output-enable vectors. A byte is driven only while its enable bit is 1. The enables are decoded from a direction input, the path select and one active-low enable per byte lane.

The block has no data streams, so there is no valid/ready interface. Every pin is a plain level-sensitive control or data signal. The block applies no back-pressure. A value is captured when its load input is high at a clock edge and is held as long as that input stays low.

Top module: `bus_exchanger_tri`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, with every load input low, `x_out`, `y_out` and `z_out` are all zero.
- R2: While `ld_xy` is 1, `y_out` equals `x_in` in the same cycle.
- R3: When a load input falls, the stage output holds the value its input had at the last rising edge with load high, and stays stable while load remains 0.
- R4: `ld_xz` loads the odd write stage (`z_out`) from `x_in` and leaves `y_out` unchanged. `ld_xy` likewise leaves `z_out` unchanged.
- R5: `ld_yx` loads the even read stage from `y_in`, and `ld_zx` loads the odd read stage from `z_in`, each independently of the other.
- R6: `x_out` shows the even read stage when `path_even`=1 and the odd read stage when `path_even`=0.
- R7: `x_oe[i]` = NOT `dir_tx` AND NOT `byte_oe_n[i]`. Lane 0 is bits [7:0] and lane 1 is bits [15:8].
- R8: `y_oe[i]` = `dir_tx` AND `path_even` AND NOT `byte_oe_n[i]`.
- R9: `z_oe[i]` = `dir_tx` AND NOT `path_even` AND NOT `byte_oe_n[i]`.
- R10: At most one port drives any byte lane. X never drives at the same time as Y or Z, and Y and Z never drive together.
- R11: The byte enables gate only the drivers. Both bytes of a stage load even when both `byte_oe_n` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the holding stages |
| rst_n | input | 1 | Asynchronous active-low reset; clears all stages |
| dir_tx | input | 1 | 1 = memory ports drive (X to memory); 0 = X drives |
| path_even | input | 1 | 1 selects the even path (Y), 0 selects the odd path (Z) |
| byte_oe_n | input | 2 | Active-low output enable per byte lane |
| ld_xy | input | 1 | Load the even write stage from X |
| ld_xz | input | 1 | Load the odd write stage from X |
| ld_yx | input | 1 | Load the even read stage from Y |
| ld_zx | input | 1 | Load the odd read stage from Z |
| x_in | input | 16 | Value sampled from the X pins |
| x_out | output | 16 | Value offered to the X pins |
| x_oe | output | 2 | Per-lane drive enable for X |
| y_in | input | 16 | Value sampled from the Y pins |
| y_out | output | 16 | Value offered to the Y pins |
| y_oe | output | 2 | Per-lane drive enable for Y |
| z_in | input | 16 | Value sampled from the Z pins |
| z_out | output | 16 | Value offered to the Z pins |
| z_oe | output | 2 | Per-lane drive enable for Z |

## Verification
The bench builds the block with its default values: 8-bit lanes and two lanes. At that size all 16 combinations of direction, path and lane enables can be swept, and every enable bit of every port is checked in each combination. Each holding stage goes through several arithmetic data patterns. Each pattern is checked first while the stage is transparent and again after its load input falls, with the input changed in between. This shows both the capture edge and that the neighbouring stages are left alone.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic {
    BX_DIR_TO_CPU = 1'b0,
    BX_DIR_TO_MEM = 1'b1
  } bx_dir_e;

  typedef enum logic {
    BX_PATH_ODD  = 1'b0,
    BX_PATH_EVEN = 1'b1
  } bx_path_e;
endpackage

// File: rtl/bx_hold_cell.sv
module bx_hold_cell #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d;
  end

  assign q = le ? d : held;

  // R3: once load has fallen, the output shows what was present at the last enabled edge
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(le) && !le) |-> (q == $past(d)));

  // R3: output stays put while load stays low
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(le) && !le) |-> $stable(q));
endmodule

// File: rtl/bx_latch_word.sv
module bx_latch_word #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bx_hold_cell #(.W(LANE_W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .le   (le),
      .d    (d[g*LANE_W +: LANE_W]),
      .q    (q[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/bx_oe_decode.sv
module bx_oe_decode
  import bx_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  bx_dir_e          dir,
  input  bx_path_e         path,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] x_oe,
  output logic [LANES-1:0] y_oe,
  output logic [LANES-1:0] z_oe
);
  logic to_mem, to_cpu;
  logic even_sel;

  always_comb begin
    to_mem   = (dir == BX_DIR_TO_MEM);
    to_cpu   = (dir == BX_DIR_TO_CPU);
    even_sel = (path == BX_PATH_EVEN);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign x_oe[g] = to_cpu & ~lane_n[g];
    assign y_oe[g] = to_mem &  even_sel & ~lane_n[g];
    assign z_oe[g] = to_mem & ~even_sel & ~lane_n[g];
  end
endmodule

// File: rtl/bx_read_mux.sv
module bx_read_mux
  import bx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  bx_path_e     path,
  input  logic [W-1:0] even_q,
  input  logic [W-1:0] odd_q,
  output logic [W-1:0] sel_q
);
  always_comb begin
    unique case (path)
      BX_PATH_EVEN: sel_q = even_q;
      default:      sel_q = odd_q;
    endcase
  end
endmodule

// File: rtl/bus_exchanger_tri.sv
module bus_exchanger_tri
  import bx_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_tx,
  input  logic             path_even,
  input  logic [LANES-1:0] byte_oe_n,
  input  logic             ld_xy,
  input  logic             ld_xz,
  input  logic             ld_yx,
  input  logic             ld_zx,
  input  logic [W-1:0]     x_in,
  output logic [W-1:0]     x_out,
  output logic [LANES-1:0] x_oe,
  input  logic [W-1:0]     y_in,
  output logic [W-1:0]     y_out,
  output logic [LANES-1:0] y_oe,
  input  logic [W-1:0]     z_in,
  output logic [W-1:0]     z_out,
  output logic [LANES-1:0] z_oe
);
  bx_dir_e  dir_e;
  bx_path_e path_e;
  logic [W-1:0] rd_even_q, rd_odd_q;

  assign dir_e  = bx_dir_e'(dir_tx);
  assign path_e = bx_path_e'(path_even);

  bx_latch_word #(.LANE_W(LANE_W), .LANES(LANES)) u_wr_even (
    .clk(clk), .rst_n(rst_n), .le(ld_xy), .d(x_in), .q(y_out));

  bx_latch_word #(.LANE_W(LANE_W), .LANES(LANES)) u_wr_odd (
    .clk(clk), .rst_n(rst_n), .le(ld_xz), .d(x_in), .q(z_out));

  bx_latch_word #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_even (
    .clk(clk), .rst_n(rst_n), .le(ld_yx), .d(y_in), .q(rd_even_q));

  bx_latch_word #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_odd (
    .clk(clk), .rst_n(rst_n), .le(ld_zx), .d(z_in), .q(rd_odd_q));

  bx_read_mux #(.W(W)) u_mux (
    .path(path_e), .even_q(rd_even_q), .odd_q(rd_odd_q), .sel_q(x_out));

  bx_oe_decode #(.LANES(LANES)) u_oe (
    .dir(dir_e), .path(path_e), .lane_n(byte_oe_n),
    .x_oe(x_oe), .y_oe(y_oe), .z_oe(z_oe));

  // R10: X never drives together with a memory port
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !((|x_oe) && ((|y_oe) || (|z_oe))));

  // R10: the two memory ports are never driven together
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((|y_oe) && (|z_oe)));

  // R2: the even write stage is transparent while loading
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    ld_xy |-> (y_out == x_in));

  // R6: with both read stages transparent, X follows the selected memory input
  a_r6_path_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_yx && ld_zx) |-> (x_out == (path_even ? y_in : z_in)));
endmodule

// File: tb/bus_exchanger_tri_bench.sv
`timescale 1ns/1ps
module bus_exchanger_tri_bench;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int W      = LANE_W * LANES;

  logic clk = 1'b0;
  logic rst_n;
  logic dir_tx, path_even;
  logic [LANES-1:0] byte_oe_n;
  logic ld_xy, ld_xz, ld_yx, ld_zx;
  logic [W-1:0] x_in, y_in, z_in;
  logic [W-1:0] x_out, y_out, z_out;
  logic [LANES-1:0] x_oe, y_oe, z_oe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bus_exchanger_tri #(.LANE_W(LANE_W), .LANES(LANES)) u_bus_exchanger_tri (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .path_even(path_even),
    .byte_oe_n(byte_oe_n), .ld_xy(ld_xy), .ld_xz(ld_xz), .ld_yx(ld_yx),
    .ld_zx(ld_zx), .x_in(x_in), .x_out(x_out), .x_oe(x_oe),
    .y_in(y_in), .y_out(y_out), .y_oe(y_oe), .z_in(z_in), .z_out(z_out),
    .z_oe(z_oe));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_tx = 1'b0; path_even = 1'b1; byte_oe_n = '1;
    ld_xy = 0; ld_xz = 0; ld_yx = 0; ld_zx = 0;
    x_in = 16'hA5A5; y_in = 16'h5A5A; z_in = 16'hC3C3;
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    // R1: cleared stages
    chk("R1 y_out", y_out, '0);
    chk("R1 z_out", z_out, '0);
    chk("R1 x_out even", x_out, '0);
    path_even = 1'b0; #1;
    chk("R1 x_out odd", x_out, '0);

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b, c, d, e, f;
      a = W'(16'h1357 * (i + 1)) ^ 16'h8001;
      b = ~a;
      c = W'(16'h2468 * (i + 3)) ^ 16'h00FF;
      d = W'(16'h0F0F + 16'h1111 * i);
      e = c ^ 16'hFFFF;
      f = d + 16'h0101;
      byte_oe_n = 2'b11; // R11: drivers off, stages must still load both bytes
      // even write stage
      step();
      x_in = a; ld_xy = 1; #1;
      chk("R2 transparent y", y_out, a);
      step();
      ld_xy = 0; x_in = b; #1;
      chk("R3 hold y", y_out, a);
      chk("R11 upper byte loaded", {8'h00, y_out[15:8]}, {8'h00, a[15:8]});
      // odd write stage
      step();
      x_in = b; ld_xz = 1; #1;
      chk("R4 odd write", z_out, b);
      chk("R4 even untouched", y_out, a);
      step();
      ld_xz = 0; x_in = a ^ 16'h3C3C; #1;
      chk("R3 hold z", z_out, b);
      step(); #1;
      chk("R3 hold z later", z_out, b);
      // read stages
      step();
      y_in = c; ld_yx = 1; path_even = 1; #1;
      chk("R5 even read transparent", x_out, c);
      step();
      ld_yx = 0; y_in = e; z_in = d; ld_zx = 1; path_even = 0; #1;
      chk("R5 odd read transparent", x_out, d);
      step();
      ld_zx = 0; z_in = f; #1;
      chk("R6 path odd", x_out, d);
      path_even = 1; #1;
      chk("R6 path even", x_out, c);
      chk("R5 even unaffected by odd load", x_out, c);
    end

    // R7/R8/R9/R10: full control sweep
    for (int k = 0; k < 16; k++) begin
      logic dt, pe;
      logic [1:0] bn, ex, ey, ez;
      dt = k[3]; pe = k[2]; bn = k[1:0];
      ex = dt ? 2'b00 : ~bn;
      ey = (dt && pe) ? ~bn : 2'b00;
      ez = (dt && !pe) ? ~bn : 2'b00;
      step();
      dir_tx = dt; path_even = pe; byte_oe_n = bn; #1;
      chk("R7 x_oe", {14'd0, x_oe}, {14'd0, ex});
      chk("R8 y_oe", {14'd0, y_oe}, {14'd0, ey});
      chk("R9 z_oe", {14'd0, z_oe}, {14'd0, ez});
      chk("R10 single driver", {15'd0, ((|x_oe) && (|(y_oe | z_oe))) || ((|y_oe) && (|z_oe))}, '0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule